// File: doc/BRIEF.md
# PWM input period/duty capture

This block measures an external pulse-width-modulated signal in counter ticks. One of two input pins is chosen as the measured source. It passes through a two-stage synchroniser and then an edge detector. A free-running counter with its own tick divider and a programmable top value provides the time base. Rising edges stamp the counter into a first capture register and falling edges stamp it into a second one.

A start strobe restarts the time base and clears any measurement in progress. The first qualified rising edge stores the reference stamp. The second qualified rising edge ends the measurement: the block then takes the period and the high time from the stamps, handles counter wrap, applies the corrections for stale falling-edge stamps and for the input edge divider, and raises `done`. An input edge divider can make only every 2nd, 4th or 8th edge of each polarity count. If the second rising edge does not arrive within a programmable number of counter wraps, `timeout` is raised instead. Converting ticks to time units is left to the consumer.

Top module: `pwm_capture_meter`

## Requirements
- R1: While reset is held, `done`, `timeout`, `period_ticks` and `duty_ticks` are all 0.
- R2: `pin_sel` = 0 measures `pin_a` and `pin_sel` = 1 measures `pin_b`. Activity on the other pin has no effect on any output.
- R3: A `start` strobe clears `done` and `timeout` on the next cycle. It restarts the counter and its tick divider at 0, resets both edge dividers and the falling-edge stamp to 0, and discards a reference stamp already taken.
- R4: While measuring, the counter advances once every `tick_div`+1 clock cycles, counting 0 up to `max_count` and then returning to 0.
- R5: The first qualified rising edge after start stores the counter as t0. At the second qualified rising edge the counter value is t2, and t1 is the current falling-edge stamp. The falling-edge stamp is reloaded on every qualified falling edge.
- R6: Each difference later−earlier is taken directly when later ≥ earlier. Otherwise it is `max_count` − earlier + later. The raw period is the difference from t0 to t2, and the raw duty is the difference from t0 to t1.
- R7: If the raw duty exceeds the raw period, the raw period is subtracted from it once.
- R8: `edge_div` code 0, 1, 2 or 3 qualifies every 1st, 2nd, 4th or 8th edge, counted separately for rising and falling edges. `period_ticks` is the raw period shifted right by the code.
- R9: With a non-zero code, when the duty from R7 is ≥ `period_ticks`, the duty becomes `period_ticks` + duty − raw period, clamped at 0.
- R10: `done` rises at the third clock edge after the pin change that forms the completing rising edge. The results and `done` then hold, later pin edges are ignored and the counter stays stopped until the next `start`.
- R11: If the counter wraps for the (`wrap_limit`+1)-th time before completion, `timeout` rises in that cycle, the measurement stops and `done` stays 0.
- R12: With parameter `DUAL_UNIT` = 0 (one capture unit), `duty_ticks` is always 0 while the period is unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle strobe that begins a new measurement |
| pin_a | input | 1 | Candidate measured input 0 |
| pin_b | input | 1 | Candidate measured input 1 |
| pin_sel | input | 1 | Selects the measured pin |
| tick_div | input | PSC_W | Counter tick divider, one tick per tick_div+1 cycles |
| max_count | input | CNT_W | Top value of the counter |
| edge_div | input | 2 | Input edge divider code |
| wrap_limit | input | WRAP_W | Counter wraps allowed before timeout |
| period_ticks | output | CNT_W | Measured period in ticks |
| duty_ticks | output | CNT_W | Measured high time in ticks |
| done | output | 1 | Measurement complete |
| timeout | output | 1 | Measurement abandoned |

## Verification
A pin change applied before clock edge E goes through two synchroniser stages and the edge stage, so its stamp is written at edge E+2 and holds the counter value left by edge E+1. The bench therefore predicts every stamp from the number of clock edges between start and E+1, and from that derives the expected results. It checks that `done` is still low two cycles after the completing pin change and high with the predicted values one cycle later. For timeout it samples in the cycle just before the predicted wrap and in the cycle of that wrap. Hold checks follow further pin edges issued after completion.

// File: rtl/pwm_capture_meter.sv
module pwm_capture_meter #(
  parameter int CNT_W     = 16,
  parameter int PSC_W     = 8,
  parameter int WRAP_W    = 8,
  parameter bit DUAL_UNIT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              pin_a,
  input  logic              pin_b,
  input  logic              pin_sel,
  input  logic [PSC_W-1:0]  tick_div,
  input  logic [CNT_W-1:0]  max_count,
  input  logic [1:0]        edge_div,
  input  logic [WRAP_W-1:0] wrap_limit,
  output logic [CNT_W-1:0]  period_ticks,
  output logic [CNT_W-1:0]  duty_ticks,
  output logic              done,
  output logic              timeout
);

  localparam int EXT_W = CNT_W + 2;

  logic              sync1, sync2, prev;
  logic              busy, have_t0;
  logic [PSC_W-1:0]  psc_cnt;
  logic [CNT_W-1:0]  cnt, t0, cap2;
  logic [WRAP_W-1:0] wrap_cnt;
  logic [2:0]        rise_div, fall_div, edge_lim;

  function automatic logic [CNT_W-1:0] span(input logic [CNT_W-1:0] a,
                                            input logic [CNT_W-1:0] b,
                                            input logic [CNT_W-1:0] m);
    return (b >= a) ? b - a : m - a + b;
  endfunction

  // input selection, synchroniser and edge detection
  wire pin_mux = pin_sel ? pin_b : pin_a;
  wire rise    = sync2 & ~prev;
  wire fall    = ~sync2 & prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b0;
      sync2 <= 1'b0;
      prev  <= 1'b0;
    end else begin
      sync1 <= pin_mux;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  assign edge_lim = 3'((4'd1 << edge_div) - 4'd1);

  wire live   = busy && !start;
  wire rise_q = live && rise && (rise_div == edge_lim);
  wire fall_q = live && fall && (fall_div == edge_lim);
  wire tick   = busy && (psc_cnt == tick_div);
  wire wrap   = tick && (cnt == max_count);

  // result arithmetic on the stamps
  logic [CNT_W-1:0] raw_p, d0, d1, per_sh, d2;
  logic [EXT_W-1:0] corr;

  always_comb begin
    raw_p  = span(t0, cnt, max_count);
    d0     = DUAL_UNIT ? span(t0, cap2, max_count) : '0;
    d1     = (d0 > raw_p) ? d0 - raw_p : d0;
    per_sh = raw_p >> edge_div;
    corr   = {2'b00, per_sh} + {2'b00, d1} - {2'b00, raw_p};
    if (edge_div != 2'd0 && d1 >= per_sh)
      d2 = corr[EXT_W-1] ? '0 : corr[CNT_W-1:0];
    else
      d2 = d1;
    if (!DUAL_UNIT) d2 = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy         <= 1'b0;
      have_t0      <= 1'b0;
      psc_cnt      <= '0;
      cnt          <= '0;
      wrap_cnt     <= '0;
      rise_div     <= '0;
      fall_div     <= '0;
      t0           <= '0;
      cap2         <= '0;
      period_ticks <= '0;
      duty_ticks   <= '0;
      done         <= 1'b0;
      timeout      <= 1'b0;
    end else if (start) begin
      busy     <= 1'b1;
      have_t0  <= 1'b0;
      psc_cnt  <= '0;
      cnt      <= '0;
      wrap_cnt <= '0;
      rise_div <= '0;
      fall_div <= '0;
      cap2     <= '0;
      done     <= 1'b0;
      timeout  <= 1'b0;
    end else if (busy) begin
      if (tick) begin
        psc_cnt <= '0;
        cnt     <= wrap ? '0 : cnt + 1'b1;
      end else begin
        psc_cnt <= psc_cnt + 1'b1;
      end
      if (rise) rise_div <= (rise_div == edge_lim) ? 3'd0 : rise_div + 3'd1;
      if (fall) fall_div <= (fall_div == edge_lim) ? 3'd0 : fall_div + 3'd1;
      if (fall_q) cap2 <= cnt;
      if (rise_q && !have_t0) begin
        t0      <= cnt;
        have_t0 <= 1'b1;
      end
      if (rise_q && have_t0) begin
        period_ticks <= per_sh;
        duty_ticks   <= d2;
        done         <= 1'b1;
        busy         <= 1'b0;
      end else if (wrap) begin
        if (wrap_cnt == wrap_limit) begin
          timeout <= 1'b1;
          busy    <= 1'b0;
        end else begin
          wrap_cnt <= wrap_cnt + 1'b1;
        end
      end
    end
  end

  assert_flags_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout));

  assert_start_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && !done && !timeout && cnt == '0));

  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(period_ticks) && $stable(duty_ticks)));

  assert_counter_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(cnt));

  assert_counter_paced_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start && !tick) |=> $stable(cnt));

  generate
    if (!DUAL_UNIT) begin : g_single
      assert_single_duty_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (duty_ticks == '0));
    end
  endgenerate

endmodule

// File: tb/pwm_capture_meter_tb_top.sv
module pwm_capture_meter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        pin_a = 1'b0;
  logic        pin_b = 1'b0;
  logic        pin_sel = 1'b0;
  logic [7:0]  tick_div = '0;
  logic [15:0] max_count = 16'd100;
  logic [1:0]  edge_div = '0;
  logic [7:0]  wrap_limit = 8'd255;
  logic [15:0] period_ticks, duty_ticks, s_period, s_duty;
  logic        done, timeout, s_done, s_timeout;

  int pc = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) pc <= pc + 1;

  pwm_capture_meter dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .pin_a(pin_a), .pin_b(pin_b),
    .pin_sel(pin_sel), .tick_div(tick_div), .max_count(max_count),
    .edge_div(edge_div), .wrap_limit(wrap_limit), .period_ticks(period_ticks),
    .duty_ticks(duty_ticks), .done(done), .timeout(timeout));

  pwm_capture_meter #(.DUAL_UNIT(1'b0)) dut_single_i (
    .clk(clk), .rst_n(rst_n), .start(start), .pin_a(pin_a), .pin_b(pin_b),
    .pin_sel(pin_sel), .tick_div(tick_div), .max_count(max_count),
    .edge_div(edge_div), .wrap_limit(wrap_limit), .period_ticks(s_period),
    .duty_ticks(s_duty), .done(s_done), .timeout(s_timeout));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic tick_neg();
    @(negedge clk);
    if (pin_sel) pin_a = 1'($urandom_range(0, 1));
    else         pin_b = 1'($urandom_range(0, 1));
  endtask

  task automatic drive_sel(input bit v);
    if (pin_sel) pin_b = v; else pin_a = v;
  endtask

  function automatic int span(input int a, input int b, input int m);
    return (b >= a) ? b - a : m - a + b;
  endfunction

  function automatic int capv(input int e, input int s, input int d, input int m);
    return ((e + 1 - s) / (d + 1)) % (m + 1);
  endfunction

  task automatic pulse_start(output int s);
    start = 1'b1;
    s = pc + 1;
    tick_neg();
    start = 1'b0;
  endtask

  task automatic run_meas(input bit sel, input int d, input int m, input int code,
                          input int h, input int l, input int phase, input bit hi0,
                          input string tag);
    int s, n, rk, fk, t0, t1, t2, c2, rawp, d0, d1, psh, expd, e;
    bit lvl, have0;
    pin_sel = sel; tick_div = 8'(d); max_count = 16'(m); edge_div = 2'(code);
    wrap_limit = 8'd255;
    drive_sel(hi0);
    lvl = hi0;
    repeat (6) tick_neg();
    pulse_start(s);
    chk(!done && !timeout, {tag, " R3 start clears flags"}, done, 0);
    n = 1 << code; rk = 0; fk = 0; c2 = 0; have0 = 0; t0 = 0; t1 = 0; t2 = 0;
    repeat (phase - 1) tick_neg();
    forever begin
      lvl = ~lvl;
      drive_sel(lvl);
      e = pc + 1;
      if (lvl) begin
        rk++;
        if (rk % n == 0) begin
          if (!have0) begin t0 = capv(e, s, d, m); have0 = 1; end
          else begin t2 = capv(e, s, d, m); t1 = c2; break; end
        end
      end else begin
        fk++;
        if (fk % n == 0) c2 = capv(e, s, d, m);
      end
      repeat (lvl ? h : l) tick_neg();
    end
    rawp = span(t0, t2, m);
    d0 = span(t0, t1, m);
    d1 = (d0 > rawp) ? d0 - rawp : d0;
    psh = rawp >> code;
    expd = d1;
    if (code != 0 && d1 >= psh) begin
      expd = psh + d1 - rawp;
      if (expd < 0) expd = 0;
    end
    tick_neg(); tick_neg();
    chk(!done, {tag, " R10 done not early"}, done, 0);
    tick_neg();
    chk(done && !timeout, {tag, " R10 done on third edge"}, done, 1);
    chk(period_ticks == 16'(psh), {tag, " R5 R6 R8 period"}, period_ticks, psh);
    chk(duty_ticks == 16'(expd), {tag, " R6 R7 R9 duty"}, duty_ticks, expd);
    chk(s_done && s_period == 16'(psh) && s_duty == 16'd0, {tag, " R12 single unit"}, s_duty, 0);
    for (int k = 0; k < 3; k++) begin
      lvl = ~lvl;
      drive_sel(lvl);
      repeat (3) tick_neg();
    end
    chk(done && period_ticks == 16'(psh) && duty_ticks == 16'(expd),
        {tag, " R10 results hold"}, duty_ticks, expd);
    drive_sel(1'b0);
    repeat (4) tick_neg();
  endtask

  initial begin
    int s, seed;
    seed = int'($urandom(32'hC0FFEE));
    repeat (3) @(negedge clk);
    chk(!done && !timeout && period_ticks == 16'd0 && duty_ticks == 16'd0,
        "R1 reset state", period_ticks, 0);
    rst_n = 1'b1;
    repeat (2) tick_neg();

    run_meas(1'b0, 0, 200, 0, 5, 7, 1, 1'b0, "basic pin_a");
    run_meas(1'b1, 0, 200, 0, 3, 9, 2, 1'b0, "R2 pin_b");
    run_meas(1'b0, 0, 9, 0, 4, 7, 1, 1'b0, "R6 R7 wrap");
    run_meas(1'b0, 1, 300, 0, 6, 6, 3, 1'b0, "R4 tick div");
    run_meas(1'b0, 0, 500, 1, 5, 3, 1, 1'b1, "R9 code1 high start");
    run_meas(1'b1, 0, 500, 2, 4, 6, 2, 1'b1, "R8 code2");
    run_meas(1'b0, 0, 500, 3, 3, 2, 1, 1'b0, "R8 code3");

    // restart in the middle of a measurement
    pin_sel = 1'b0; edge_div = 2'd0; tick_div = 8'd0; max_count = 16'd200;
    pulse_start(s);
    repeat (2) tick_neg();
    drive_sel(1'b1); repeat (5) tick_neg();
    drive_sel(1'b0); repeat (5) tick_neg();
    run_meas(1'b0, 0, 200, 0, 4, 4, 2, 1'b0, "R3 restart");

    for (int i = 0; i < 30; i++) begin
      run_meas(1'($urandom_range(0, 1)), $urandom_range(0, 3), $urandom_range(20, 500),
               $urandom_range(0, 3), $urandom_range(2, 12), $urandom_range(2, 12),
               $urandom_range(1, 5), 1'($urandom_range(0, 1)), "random");
    end

    // timeout: counter tick every 2 cycles, top 7, third wrap at edge S+48
    pin_sel = 1'b0; drive_sel(1'b0); tick_div = 8'd1; max_count = 16'd7;
    edge_div = 2'd0; wrap_limit = 8'd2;
    repeat (5) tick_neg();
    pulse_start(s);
    while (pc < s + 47) tick_neg();
    chk(!timeout && !done, "R11 no timeout before last wrap", timeout, 0);
    tick_neg();
    chk(timeout && !done, "R11 timeout on wrap", timeout, 1);
    chk(s_timeout, "R11 timeout single unit", s_timeout, 1);
    repeat (20) tick_neg();
    chk(timeout && !done, "R11 timeout holds", timeout, 1);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(10 * 150000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule